// File: doc/BRIEF.md
# Nonvolatile Transfer Sequencer

This block is the control state machine that moves data between a volatile SRAM array and the nonvolatile shadow cells behind it. It issues a recall when the supply comes up, and a store when the supply is lost. It also accepts a store requested from an external open-drain busy pin, and store or recall requests from software. During any transfer it blocks SRAM access. It drives the busy pin low while a store runs.

An external comparator reduces the supply to a single flag, `pwr_ok`. Transfer lengths are fixed cycle counts set by parameters. A dirty flag records whether the SRAM has been written since the last transfer. Every store request, from any source, is dropped when the flag is clear. All control pins are plain levels or single-cycle pulses. There is no streaming interface and no back-pressure.

Top module: `nv_xfer_seq`

## Requirements
- R1: While reset is held and after it is released with `pwr_ok` low, the block is powered off: `rw_inhibit`=1 and `store_cmd`, `recall_cmd`, `busy_drive_low` are 0. Automatic store on supply loss starts out enabled.
- R2: In the power-off state, the first rising clock edge that samples `pwr_ok`=1 starts a recall. `recall_cmd` is then 1 for exactly RECALL_CYC cycles, after which the block is idle.
- R3: `rw_inhibit` is 1 whenever the block is not idle. At most one of `store_cmd` and `recall_cmd` is 1 at any time.
- R4: The dirty flag is set only by an `sram_wr` pulse sampled while `rw_inhibit`=0. It is cleared when a store or a recall completes.
- R5: A store trigger of any kind is ignored when the dirty flag is clear, so `store_cmd` stays 0.
- R6: When idle with automatic store enabled and the flag dirty, sampling `pwr_ok`=0 starts a store. `store_cmd` is then 1 for STORE_CYC cycles.
- R7: A pulse on `sw_auto_dis` disables automatic store. A pulse on `sw_auto_ena` enables it. If both pulses come in the same cycle, the disable wins. With automatic store disabled, losing the supply while idle goes straight to power-off.
- R8: A low level on `busy_pin_in` while idle and dirty starts a store. `rw_inhibit` is 1 in every cycle that `busy_pin_in` is low.
- R9: `busy_drive_low` is 1 exactly in the cycles in which `store_cmd` is 1.
- R10: While idle, `sw_store_req` starts a store if the flag is dirty. `sw_recall_req` starts a recall whatever the state of the flag. Requests that arrive while the block is not idle are ignored.
- R11: When idle triggers coincide, they are served in this order: supply loss, then pin low, then software store, then software recall. A higher-ranked trigger that is present blocks all lower ones, even when its store is skipped.
- R12: If the supply is lost during a recall, the recall aborts and the block enters power-off on the next cycle without storing.
- R13: If the supply is lost during a store, the store still runs its full length. The block then enters power-off rather than idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply is above the switch threshold |
| busy_pin_in | input | 1 | Level sensed on the open-drain busy pin, low = store request / hold |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| sw_auto_ena | input | 1 | Pulse enabling automatic store on supply loss |
| sw_auto_dis | input | 1 | Pulse disabling automatic store on supply loss |
| sram_wr | input | 1 | SRAM write strobe |
| store_cmd | output | 1 | Array store in progress |
| recall_cmd | output | 1 | Array recall in progress |
| rw_inhibit | output | 1 | SRAM reads and writes blocked |
| busy_drive_low | output | 1 | Enable for the pull-down on the busy pin |

## Verification
The bench builds the block with STORE_CYC=5 and RECALL_CYC=3. These short counts let a test reach the end of each transfer in a few cycles. They also make it easy to drop the supply in the middle of a recall or a store. A behavioural model is compared against all four outputs on every cycle. The stimulus walks through power-up, triggers arriving with the flag clean and with it dirty, triggers that coincide, the auto-store enable pulses including both in one cycle, and supply loss during each kind of transfer.

// File: rtl/nv_xfer_pkg.sv
package nv_xfer_pkg;
  typedef enum logic [1:0] {
    NV_OFF    = 2'd0,
    NV_RECALL = 2'd1,
    NV_IDLE   = 2'd2,
    NV_STORE  = 2'd3
  } nv_state_t;
endpackage

// File: rtl/nv_dirty_latch.sv
module nv_dirty_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_o <= 1'b0;
    else if (clr_i) dirty_o <= 1'b0;
    else if (set_i) dirty_o <= 1'b1;
  end

  // a set and a clear never coincide: transfers block writes (R4)
  p_no_set_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));
endmodule

// File: rtl/nv_xfer_timer.sv
module nv_xfer_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/nv_trig_arb.sv
module nv_trig_arb (
  input  logic idle_i,
  input  logic pwr_ok_i,
  input  logic pin_low_i,
  input  logic sw_store_i,
  input  logic sw_recall_i,
  input  logic dirty_i,
  input  logic auto_en_i,
  output logic go_store_o,
  output logic go_off_o,
  output logic go_recall_o
);
  logic loss, pin_ev, sws_ev, swr_ev;

  always_comb begin
    loss   = idle_i && !pwr_ok_i;
    pin_ev = idle_i && pwr_ok_i && pin_low_i;
    sws_ev = idle_i && pwr_ok_i && !pin_low_i && sw_store_i;
    swr_ev = idle_i && pwr_ok_i && !pin_low_i && !sw_store_i && sw_recall_i;
    go_store_o  = dirty_i && ((loss && auto_en_i) || pin_ev || sws_ev);
    go_off_o    = loss && !(auto_en_i && dirty_i);
    go_recall_o = swr_ev;
  end
endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq #(
  parameter int STORE_CYC  = 1000,
  parameter int RECALL_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic busy_pin_in,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic sw_auto_ena,
  input  logic sw_auto_dis,
  input  logic sram_wr,
  output logic store_cmd,
  output logic recall_cmd,
  output logic rw_inhibit,
  output logic busy_drive_low
);
  import nv_xfer_pkg::*;

  localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ST_LOAD = CNT_W'(STORE_CYC - 1);
  localparam logic [CNT_W-1:0] RC_LOAD = CNT_W'(RECALL_CYC - 1);

  nv_state_t st_q, st_d;
  logic auto_en_q;
  logic dirty, t_done, t_load, t_dec;
  logic [CNT_W-1:0] t_val;
  logic go_store, go_off, go_recall;
  logic latch_set, latch_clr;
  logic is_idle;

  assign is_idle = (st_q == NV_IDLE);

  nv_trig_arb u_arb (
    .idle_i      (is_idle),
    .pwr_ok_i    (pwr_ok),
    .pin_low_i   (!busy_pin_in),
    .sw_store_i  (sw_store_req),
    .sw_recall_i (sw_recall_req),
    .dirty_i     (dirty),
    .auto_en_i   (auto_en_q),
    .go_store_o  (go_store),
    .go_off_o    (go_off),
    .go_recall_o (go_recall)
  );

  nv_xfer_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (t_load),
    .load_val_i (t_val),
    .dec_i      (t_dec),
    .done_o     (t_done)
  );

  nv_dirty_latch u_dirty (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (latch_set),
    .clr_i   (latch_clr),
    .dirty_o (dirty)
  );

  always_comb begin
    st_d      = st_q;
    t_load    = 1'b0;
    t_val     = RC_LOAD;
    t_dec     = 1'b0;
    latch_clr = 1'b0;
    unique case (st_q)
      NV_OFF: begin
        if (pwr_ok) begin
          st_d   = NV_RECALL;
          t_load = 1'b1;
        end
      end
      NV_RECALL: begin
        if (!pwr_ok) begin
          st_d = NV_OFF;
        end else if (t_done) begin
          st_d      = NV_IDLE;
          latch_clr = 1'b1;
        end else begin
          t_dec = 1'b1;
        end
      end
      NV_IDLE: begin
        if (go_off) begin
          st_d = NV_OFF;
        end else if (go_store) begin
          st_d   = NV_STORE;
          t_load = 1'b1;
          t_val  = ST_LOAD;
        end else if (go_recall) begin
          st_d   = NV_RECALL;
          t_load = 1'b1;
        end
      end
      NV_STORE: begin
        if (t_done) begin
          st_d      = pwr_ok ? NV_IDLE : NV_OFF;
          latch_clr = 1'b1;
        end else begin
          t_dec = 1'b1;
        end
      end
      default: st_d = NV_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= NV_OFF;
      auto_en_q <= 1'b1;
    end else begin
      st_q <= st_d;
      if (sw_auto_dis)      auto_en_q <= 1'b0;
      else if (sw_auto_ena) auto_en_q <= 1'b1;
    end
  end

  assign store_cmd      = (st_q == NV_STORE);
  assign recall_cmd     = (st_q == NV_RECALL);
  assign busy_drive_low = (st_q == NV_STORE);
  assign rw_inhibit     = !is_idle || !busy_pin_in;
  assign latch_set      = sram_wr && !rw_inhibit;

  // ---------------- assertions ----------------
  p_store_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(store_cmd) |-> $past(dirty));
  p_clean_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(store_cmd) |-> !dirty);
  p_dirty_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dirty) |-> $past(sram_wr && !rw_inhibit));
  p_one_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_cmd, recall_cmd}));
  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (recall_cmd && !pwr_ok) |=> (!recall_cmd && !store_cmd && rw_inhibit));
  p_store_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_drive_low) |-> $past(is_idle));
  p_store_end_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (store_cmd && t_done && !pwr_ok) |=> (st_q == NV_OFF));
endmodule

// File: tb/nv_xfer_seq_test.sv
module nv_xfer_seq_test;
  localparam int SC = 5;
  localparam int RC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, pin_in = 1'b1;
  logic sw_st = 1'b0, sw_rc = 1'b0, a_ena = 1'b0, a_dis = 1'b0, wr = 1'b0;
  logic store_cmd, recall_cmd, rw_inhibit, busy_drive_low;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";
  bit done_flag = 0;

  always #10 clk = ~clk;

  nv_xfer_seq #(.STORE_CYC(SC), .RECALL_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .busy_pin_in(pin_in),
    .sw_store_req(sw_st), .sw_recall_req(sw_rc), .sw_auto_ena(a_ena),
    .sw_auto_dis(a_dis), .sram_wr(wr), .store_cmd(store_cmd),
    .recall_cmd(recall_cmd), .rw_inhibit(rw_inhibit),
    .busy_drive_low(busy_drive_low));

  // behavioural model: mode 0 off, 1 recall, 2 idle, 3 store
  int m_mode, m_left;
  bit m_dirty, m_auto;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_dirty = 0; m_auto = 1;
    end else begin
      bit open;
      int nm, nl;
      bit nd;
      open = (m_mode == 2) && pin_in;
      nd = m_dirty || (wr && open);
      nm = m_mode; nl = m_left;
      if (m_mode == 0) begin
        if (pwr_ok) begin nm = 1; nl = RC; end
      end else if (m_mode == 1) begin
        if (!pwr_ok) nm = 0;
        else if (m_left == 1) begin nm = 2; nd = 0; end
        else nl = m_left - 1;
      end else if (m_mode == 3) begin
        if (m_left == 1) begin nm = pwr_ok ? 2 : 0; nd = 0; end
        else nl = m_left - 1;
      end else begin
        if (!pwr_ok) begin
          if (m_auto && m_dirty) begin nm = 3; nl = SC; end else nm = 0;
        end else if (!pin_in) begin
          if (m_dirty) begin nm = 3; nl = SC; end
        end else if (sw_st) begin
          if (m_dirty) begin nm = 3; nl = SC; end
        end else if (sw_rc) begin
          nm = 1; nl = RC;
        end
      end
      if (a_dis) m_auto = 0; else if (a_ena) m_auto = 1;
      m_mode = nm; m_left = nl; m_dirty = nd;
    end
  end

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d",
               cur_req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      chk("store_cmd", store_cmd, m_mode == 3);
      chk("recall_cmd", recall_cmd, m_mode == 1);
      chk("busy_drive_low", busy_drive_low, m_mode == 3);
      chk("rw_inhibit", rw_inhibit, (m_mode != 2) || !pin_in);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done_flag) begin
      done_flag = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic write_pulse();
    wr = 1; cyc(1); wr = 0;
  endtask

  initial begin
    cyc(2);
    cur_req = "R1";
    chk("store_cmd", store_cmd, 1'b0);
    chk("recall_cmd", recall_cmd, 1'b0);
    chk("rw_inhibit", rw_inhibit, 1'b1);
    chk("busy_drive_low", busy_drive_low, 1'b0);
    rst_n = 1; cyc(3);
    cur_req = "R2"; pwr_ok = 1; cyc(1);
    chk("recall after power-up R2", recall_cmd, 1'b1);
    cyc(RC + 2);
    chk("idle after recall R2", rw_inhibit, 1'b0);
    cur_req = "R5"; sw_st = 1; cyc(1); sw_st = 0; cyc(3);
    chk("no store when clean R5", store_cmd, 1'b0);
    cur_req = "R10"; write_pulse(); sw_st = 1; cyc(1); sw_st = 0;
    chk("sw store R10", store_cmd, 1'b1);
    sw_rc = 1; cyc(1); sw_rc = 0; cyc(SC + 2);
    cur_req = "R5"; sw_st = 1; cyc(1); sw_st = 0; cyc(3);
    cur_req = "R10"; write_pulse(); sw_rc = 1; cyc(1); sw_rc = 0; cyc(RC + 2);
    cur_req = "R8"; write_pulse(); pin_in = 0; cyc(1);
    chk("pin store R8", store_cmd, 1'b1);
    cyc(SC + 3);
    chk("pin held inhibits R8", rw_inhibit, 1'b1);
    pin_in = 1; cyc(2);
    cur_req = "R4"; sw_rc = 1; cyc(1); sw_rc = 0; write_pulse(); cyc(RC + 1);
    sw_st = 1; cyc(1); sw_st = 0; cyc(2);
    chk("write while inhibited ignored R4", store_cmd, 1'b0);
    cur_req = "R11"; write_pulse(); pin_in = 0; sw_st = 1; sw_rc = 1; cyc(1);
    pin_in = 1; sw_st = 0; sw_rc = 0; cyc(SC + 2);
    sw_st = 1; sw_rc = 1; cyc(1); sw_st = 0; sw_rc = 0; cyc(2);
    chk("clean sw store blocks recall R11", recall_cmd, 1'b0);
    write_pulse(); pwr_ok = 0; sw_st = 1; cyc(1); sw_st = 0;
    cur_req = "R6"; cyc(SC + 2);
    chk("off after autostore R6", rw_inhibit, 1'b1);
    pwr_ok = 1; cyc(2);
    cur_req = "R12"; pwr_ok = 0; cyc(2); pwr_ok = 1; cyc(RC + 2);
    cur_req = "R7"; a_dis = 1; cyc(1); a_dis = 0; write_pulse();
    pwr_ok = 0; cyc(2);
    chk("no autostore when disabled R7", store_cmd, 1'b0);
    pwr_ok = 1; cyc(RC + 2);
    a_dis = 1; a_ena = 1; cyc(1); a_dis = 0; a_ena = 0;
    write_pulse(); pwr_ok = 0; cyc(2); pwr_ok = 1; cyc(RC + 2);
    a_ena = 1; cyc(1); a_ena = 0; write_pulse(); pwr_ok = 0; cyc(SC + 2);
    pwr_ok = 1; cyc(RC + 2);
    cur_req = "R13"; write_pulse(); sw_st = 1; cyc(1); sw_st = 0; cyc(2);
    pwr_ok = 0; cyc(SC + 2);
    cur_req = "R3"; pwr_ok = 1; cyc(RC + 3);
    cur_req = "R9"; write_pulse(); pin_in = 0; cyc(2); pin_in = 1; cyc(SC + 2);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule